// File: doc/BRIEF.md
# Indexed Logical-Device Configuration Space

This block is the configuration register file of a multi-function peripheral controller. The host reaches it through two byte-wide ports. Offset 0 is an index port that holds a register number. Offset 1 is a data port that reads or writes the register that the index points at. One global register picks the current logical device. The per-device registers at index 0x30 and above then act on that device's bank. Nine banks exist, numbered 0 to 8.

Each bank holds these fields:
- an activate flag
- a 16-bit I/O base address
- an interrupt number
- a trigger type made of a level/edge bit and a high/low polarity bit
- two DMA channel selects
- a range-check control

The activate flags, bases, interrupt numbers and DMA channels of all banks leave the block as flat vectors. The function blocks and the address decoders use them. A fixed chip identifier can be read at index 0x20.

Range checking has a diagnostic pattern. When range checking is enabled and the device is inactive, the pattern appears on a per-device output. This lets the downstream decode return a known byte in place of real device data.

Top module: `ldev_cfg_space`

## Requirements
- R1: A write to port offset 0 sets the index register. A read at offset 0 returns the index. A data-port access (offset 1) reads or writes the register whose number the index holds. The index resets to 0x00.
- R2: Index 0x07 holds the selected logical device number, 8 bits wide. It is readable and writable, and it resets to 0.
- R3: Index 0x20 reads as 0xC0 when the revision parameter is 0. Writes to index 0x20 are ignored.
- R4: Bit 0 of index 0x30 is the activate flag of the selected device. It reads back in bit 0, with bits 7:1 reading 0. It drives bit i of dev_active. Only the selected bank changes.
- R5: Index 0x60 holds base bits 15:8 and index 0x61 holds base bits 7:0 of the selected device. Device i's base appears on dev_base[16*i+15:16*i].
- R6: Index 0x70 holds the interrupt number, exported on dev_irq[8*i+7:8*i]. Index 0x71 keeps bit 0 (trigger: 1 = level, 0 = edge) and bit 1 (polarity: 1 = high, 0 = low). Bits 7:2 of 0x71 read 0.
- R7: Indexes 0x74 and 0x75 hold the first and second DMA channel selects. They are exported on dev_dma0[8*i+7:8*i] and dev_dma1[8*i+7:8*i].
- R8: Index 0x31 keeps bit 1 (range-check enable) and bit 0 (pattern select), with bits 7:2 reading 0. dev_rchk[8*i+7:8*i] reads 0x55 when enable = 1 and select = 1 and the device is inactive. It reads 0xAA when enable = 1 and select = 0 and the device is inactive. Otherwise it reads 0x00.
- R9: Reading any index not listed in R2 to R8 returns 0x00. Writing to such an index changes no register or output.
- R10: While the selected device number is above 8, reads of the per-device indexes return 0x00 and writes to them change no bank.
- R11: After reset, every bank reads inactive and all of its fields read zero. All exported vectors are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_we | input | 1 | Write strobe for the port addressed by host_addr |
| host_addr | input | 1 | Port offset: 0 = index, 1 = data |
| host_wdata | input | 8 | Write data byte |
| host_rdata | output | 8 | Read data for the addressed port (combinational) |
| dev_active | output | NDEV | Activate flag per device |
| dev_base | output | 16*NDEV | I/O base per device |
| dev_irq | output | 8*NDEV | Interrupt number per device |
| dev_dma0 | output | 8*NDEV | First DMA channel per device |
| dev_dma1 | output | 8*NDEV | Second DMA channel per device |
| dev_rchk | output | 8*NDEV | Range-check readback pattern per device |

## Verification
The bench starts with directed sequences:
- the reset state
- chip-identifier writes
- the range-check cycle through 0x55, 0xAA and zero, with activation overriding the pattern

A long random mix then follows. It picks device numbers from 0 to 10 and indexes from both the implemented and the unimplemented set, with random data. Selector values 9 and 10 separate correct bank gating from aliasing of the selector onto a real bank. Unimplemented indexes expose decodes that are too wide. After every access the bench compares all banks' exported vectors, which catches a write that lands in a bank other than the selected one.

// File: rtl/ldc_pkg.sv
`timescale 1ns/1ps
// Package ldc_pkg
// Register index constants and the per-device bank record shared by the
// configuration space modules. Assumes 8-bit register indexes.
package ldc_pkg;
    localparam logic [7:0] IX_DEVSEL = 8'h07;
    localparam logic [7:0] IX_CHIPID = 8'h20;
    localparam logic [7:0] IX_ACT    = 8'h30;
    localparam logic [7:0] IX_RCHK   = 8'h31;
    localparam logic [7:0] IX_BASEH  = 8'h60;
    localparam logic [7:0] IX_BASEL  = 8'h61;
    localparam logic [7:0] IX_IRQ    = 8'h70;
    localparam logic [7:0] IX_ITYPE  = 8'h71;
    localparam logic [7:0] IX_DMA0   = 8'h74;
    localparam logic [7:0] IX_DMA1   = 8'h75;

    localparam logic [7:0] CHIP_ID_HI = 8'hC0;
    localparam logic [7:0] RCHK_PAT1  = 8'h55;
    localparam logic [7:0] RCHK_PAT0  = 8'hAA;

    typedef struct packed {
        logic        act;
        logic [1:0]  rchk;
        logic [15:0] base;
        logic [7:0]  irq;
        logic [1:0]  itype;
        logic [7:0]  dma0;
        logic [7:0]  dma1;
    } bank_t;
endpackage

// File: rtl/ldc_host_port.sv
`timescale 1ns/1ps
// Module ldc_host_port
// Holds the index register and the logical-device selector, and turns
// host strobes into a data-write pulse. Assumes a one-bit port offset
// and single-cycle write strobes.
module ldc_host_port (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       host_we,
    input  logic       host_addr,
    input  logic [7:0] host_wdata,
    output logic [7:0] idx,
    output logic [7:0] sel,
    output logic       data_we
);
    import ldc_pkg::*;

    // Data-port write strobe seen by all banks.
    always_comb data_we = host_we && host_addr;

    // Index register, written through port offset 0.
    always_ff @(posedge clk) begin
        if (!rst_n)
            idx <= 8'h00;
        else if (host_we && !host_addr)
            idx <= host_wdata;
    end

    // Logical-device selector, written through the data port at 0x07.
    always_ff @(posedge clk) begin
        if (!rst_n)
            sel <= 8'h00;
        else if (data_we && idx == IX_DEVSEL)
            sel <= host_wdata;
    end
endmodule

// File: rtl/ldc_bank.sv
`timescale 1ns/1ps
// Module ldc_bank
// Register bank of one logical device. It updates only when the selector
// equals DEV_ID and the index names one of its fields. Also derives the
// range-check diagnostic pattern. Assumes the selector is 8 bits wide.
module ldc_bank #(
    parameter int DEV_ID = 0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          data_we,
    input  logic [7:0]    idx,
    input  logic [7:0]    sel,
    input  logic [7:0]    wdata,
    output ldc_pkg::bank_t regs,
    output logic [7:0]    rchk_out
);
    import ldc_pkg::*;

    logic hit;

    // Write qualifies for this bank only when it is the selected device.
    always_comb hit = data_we && (sel == 8'(DEV_ID));

    // Field updates, one index per field.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            regs <= '0;
        end else if (hit) begin
            case (idx)
                IX_ACT:   regs.act        <= wdata[0];
                IX_RCHK:  regs.rchk       <= wdata[1:0];
                IX_BASEH: regs.base[15:8] <= wdata;
                IX_BASEL: regs.base[7:0]  <= wdata;
                IX_IRQ:   regs.irq        <= wdata;
                IX_ITYPE: regs.itype      <= wdata[1:0];
                IX_DMA0:  regs.dma0       <= wdata;
                IX_DMA1:  regs.dma1       <= wdata;
                default:  ;
            endcase
        end
    end

    // Diagnostic pattern, shown only while checking is on and the device is off.
    always_comb begin
        if (regs.rchk[1] && !regs.act)
            rchk_out = regs.rchk[0] ? RCHK_PAT1 : RCHK_PAT0;
        else
            rchk_out = 8'h00;
    end
endmodule

// File: rtl/ldc_read_mux.sv
`timescale 1ns/1ps
// Module ldc_read_mux
// Builds the host read byte. Offset 0 returns the index. Offset 1 returns
// the register named by the index: the global registers, or the selected
// bank's fields. Unknown indexes and selectors above NDEV-1 read zero.
module ldc_read_mux #(
    parameter int         NDEV = 9,
    parameter logic [1:0] REV  = 2'b00
) (
    input  logic                      host_addr,
    input  logic [7:0]                idx,
    input  logic [7:0]                sel,
    input  ldc_pkg::bank_t [NDEV-1:0] banks,
    output logic [7:0]                rdata
);
    import ldc_pkg::*;

    bank_t cur;

    // Pick the selected bank; an out-of-range selector yields an empty record.
    always_comb begin
        cur = '0;
        for (int i = 0; i < NDEV; i++)
            if (sel == 8'(i)) cur = banks[i];
    end

    // Register decode for the data port, index for the index port.
    always_comb begin
        if (!host_addr) begin
            rdata = idx;
        end else begin
            case (idx)
                IX_DEVSEL: rdata = sel;
                IX_CHIPID: rdata = CHIP_ID_HI | {6'b0, REV};
                IX_ACT:    rdata = {7'b0, cur.act};
                IX_RCHK:   rdata = {6'b0, cur.rchk};
                IX_BASEH:  rdata = cur.base[15:8];
                IX_BASEL:  rdata = cur.base[7:0];
                IX_IRQ:    rdata = cur.irq;
                IX_ITYPE:  rdata = {6'b0, cur.itype};
                IX_DMA0:   rdata = cur.dma0;
                IX_DMA1:   rdata = cur.dma1;
                default:   rdata = 8'h00;
            endcase
        end
    end
endmodule

// File: rtl/ldev_cfg_space.sv
`timescale 1ns/1ps
// Module ldev_cfg_space
// Top of the indexed configuration space: host port, NDEV banks built by
// generate, the read mux, and flattening of the per-device exports.
// Assumes a synchronous active-low reset and single-byte host accesses.
module ldev_cfg_space #(
    parameter int         NDEV = 9,
    parameter logic [1:0] REV  = 2'b00
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_we,
    input  logic              host_addr,
    input  logic [7:0]        host_wdata,
    output logic [7:0]        host_rdata,
    output logic [NDEV-1:0]   dev_active,
    output logic [16*NDEV-1:0] dev_base,
    output logic [8*NDEV-1:0] dev_irq,
    output logic [8*NDEV-1:0] dev_dma0,
    output logic [8*NDEV-1:0] dev_dma1,
    output logic [8*NDEV-1:0] dev_rchk
);
    import ldc_pkg::*;

    logic [7:0]           idx;
    logic [7:0]           sel;
    logic                 data_we;
    bank_t [NDEV-1:0]     banks;

    ldc_host_port u_port (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_we    (host_we),
        .host_addr  (host_addr),
        .host_wdata (host_wdata),
        .idx        (idx),
        .sel        (sel),
        .data_we    (data_we)
    );

    for (genvar g = 0; g < NDEV; g++) begin : g_bank
        ldc_bank #(.DEV_ID(g)) u_bank (
            .clk      (clk),
            .rst_n    (rst_n),
            .data_we  (data_we),
            .idx      (idx),
            .sel      (sel),
            .wdata    (host_wdata),
            .regs     (banks[g]),
            .rchk_out (dev_rchk[8*g +: 8])
        );

        // Flatten this bank's exported fields.
        always_comb begin
            dev_active[g]       = banks[g].act;
            dev_base[16*g +: 16] = banks[g].base;
            dev_irq[8*g +: 8]   = banks[g].irq;
            dev_dma0[8*g +: 8]  = banks[g].dma0;
            dev_dma1[8*g +: 8]  = banks[g].dma1;
        end
    end

    ldc_read_mux #(.NDEV(NDEV), .REV(REV)) u_rmux (
        .host_addr (host_addr),
        .idx       (idx),
        .sel       (sel),
        .banks     (banks),
        .rdata     (host_rdata)
    );
endmodule

// File: rtl/ldev_cfg_space_chk.sv
`timescale 1ns/1ps
// Module ldev_cfg_space_chk
// Protocol checker bound into ldev_cfg_space. It watches the host port,
// the index and selector state, and the exported vectors.
module ldev_cfg_space_chk #(
    parameter int         NDEV = 9,
    parameter logic [1:0] REV  = 2'b00
) (
    input logic               clk,
    input logic               rst_n,
    input logic               host_we,
    input logic               host_addr,
    input logic [7:0]         host_wdata,
    input logic [7:0]         host_rdata,
    input logic [7:0]         idx,
    input logic [7:0]         sel,
    input logic [NDEV-1:0]    dev_active,
    input logic [16*NDEV-1:0] dev_base,
    input logic [8*NDEV-1:0]  dev_rchk
);
    // R1: an index-port write lands in the index register.
    a_r1_index_load: assert property (@(posedge clk) disable iff (!rst_n)
        (host_we && !host_addr) |=> (idx == $past(host_wdata)));

    // R2: a data write at 0x07 loads the selector.
    a_r2_sel_load: assert property (@(posedge clk) disable iff (!rst_n)
        (host_we && host_addr && idx == 8'h07) |=> (sel == $past(host_wdata)));

    // R3: the identifier reads constant.
    a_r3_chip_id: assert property (@(posedge clk) disable iff (!rst_n)
        (host_addr && idx == 8'h20) |-> (host_rdata == (8'hC0 | {6'b0, REV})));

    // R4: no data write means the activate flags hold.
    a_r4_act_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(host_we && host_addr) |=> $stable(dev_active));

    // R10: writes with an out-of-range selector leave the banks untouched.
    a_r10_sel_gate: assert property (@(posedge clk) disable iff (!rst_n)
        (host_we && host_addr && sel > 8'(NDEV - 1)) |=> ($stable(dev_active) && $stable(dev_base)));

    // R11: the cycle after reset, the exports are clear.
    a_r11_reset_clear: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (dev_active == '0 && dev_base == '0 && dev_rchk == '0));

    for (genvar g = 0; g < NDEV; g++) begin : g_rc
        // R8: an active device never shows a pattern.
        a_r8_rchk_inactive: assert property (@(posedge clk) disable iff (!rst_n)
            (dev_rchk[8*g +: 8] != 8'h00) |-> !dev_active[g]);
    end
endmodule

bind ldev_cfg_space ldev_cfg_space_chk #(.NDEV(NDEV), .REV(REV)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .host_we    (host_we),
    .host_addr  (host_addr),
    .host_wdata (host_wdata),
    .host_rdata (host_rdata),
    .idx        (idx),
    .sel        (sel),
    .dev_active (dev_active),
    .dev_base   (dev_base),
    .dev_rchk   (dev_rchk)
);

// File: tb/ldev_cfg_space_tb_top.sv
`timescale 1ns/1ps
module ldev_cfg_space_tb_top;
    localparam int ND = 9;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              host_we = 1'b0;
    logic              host_addr = 1'b0;
    logic [7:0]        host_wdata = 8'h00;
    logic [7:0]        host_rdata;
    logic [ND-1:0]     dev_active;
    logic [16*ND-1:0]  dev_base;
    logic [8*ND-1:0]   dev_irq;
    logic [8*ND-1:0]   dev_dma0;
    logic [8*ND-1:0]   dev_dma1;
    logic [8*ND-1:0]   dev_rchk;

    ldev_cfg_space #(.NDEV(ND), .REV(2'b00)) dut_i (
        .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_rdata(host_rdata),
        .dev_active(dev_active), .dev_base(dev_base), .dev_irq(dev_irq),
        .dev_dma0(dev_dma0), .dev_dma1(dev_dma1), .dev_rchk(dev_rchk)
    );

    always #10 clk = ~clk;

    int nvec = 0;
    int nfail = 0;
    bit done = 0;

    // Reference model
    logic [7:0]  m_idx, m_sel;
    logic        m_act  [ND];
    logic [1:0]  m_rchk [ND];
    logic [15:0] m_base [ND];
    logic [7:0]  m_irq  [ND];
    logic [1:0]  m_ity  [ND];
    logic [7:0]  m_dma0 [ND];
    logic [7:0]  m_dma1 [ND];

    task automatic model_reset();
        m_idx = 0; m_sel = 0;
        for (int i = 0; i < ND; i++) begin
            m_act[i] = 0; m_rchk[i] = 0; m_base[i] = 0; m_irq[i] = 0;
            m_ity[i] = 0; m_dma0[i] = 0; m_dma1[i] = 0;
        end
    endtask

    function automatic logic [7:0] exp_reg(input logic [7:0] ix);
        logic ok;
        int s;
        ok = (m_sel < 8'(ND));
        s = ok ? int'(m_sel) : 0;
        case (ix)
            8'h07: return m_sel;
            8'h20: return 8'hC0;
            8'h30: return ok ? {7'b0, m_act[s]} : 8'h00;
            8'h31: return ok ? {6'b0, m_rchk[s]} : 8'h00;
            8'h60: return ok ? m_base[s][15:8] : 8'h00;
            8'h61: return ok ? m_base[s][7:0] : 8'h00;
            8'h70: return ok ? m_irq[s] : 8'h00;
            8'h71: return ok ? {6'b0, m_ity[s]} : 8'h00;
            8'h74: return ok ? m_dma0[s] : 8'h00;
            8'h75: return ok ? m_dma1[s] : 8'h00;
            default: return 8'h00;
        endcase
    endfunction

    function automatic string req_of(input logic [7:0] ix);
        case (ix)
            8'h07: return "R2";
            8'h20: return "R3";
            8'h30: return (m_sel < 8'(ND)) ? "R4" : "R10";
            8'h31: return (m_sel < 8'(ND)) ? "R8" : "R10";
            8'h60, 8'h61: return (m_sel < 8'(ND)) ? "R5" : "R10";
            8'h70, 8'h71: return (m_sel < 8'(ND)) ? "R6" : "R10";
            8'h74, 8'h75: return (m_sel < 8'(ND)) ? "R7" : "R10";
            default: return "R9";
        endcase
    endfunction

    function automatic logic [7:0] exp_rchk(input int i);
        if (m_rchk[i][1] && !m_act[i]) return m_rchk[i][0] ? 8'h55 : 8'hAA;
        return 8'h00;
    endfunction

    task automatic model_data_write(input logic [7:0] d);
        int s;
        if (m_idx == 8'h07) begin
            m_sel = d;
        end else if (m_sel < 8'(ND)) begin
            s = int'(m_sel);
            case (m_idx)
                8'h30: m_act[s] = d[0];
                8'h31: m_rchk[s] = d[1:0];
                8'h60: m_base[s][15:8] = d;
                8'h61: m_base[s][7:0] = d;
                8'h70: m_irq[s] = d;
                8'h71: m_ity[s] = d[1:0];
                8'h74: m_dma0[s] = d;
                8'h75: m_dma1[s] = d;
                default: ;
            endcase
        end
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        nvec++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One host write; returns after the edge has updated the design.
    task automatic acc(input logic a, input logic [7:0] d);
        @(negedge clk);
        host_we = 1'b1; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_we = 1'b0;
        if (!a) m_idx = d; else model_data_write(d);
    endtask

    task automatic check_all();
        host_addr = 1'b0; #1;
        check("R1", {24'b0, host_rdata}, {24'b0, m_idx});
        host_addr = 1'b1; #1;
        check(req_of(m_idx), {24'b0, host_rdata}, {24'b0, exp_reg(m_idx)});
        for (int i = 0; i < ND; i++) begin
            check("R4", {31'b0, dev_active[i]}, {31'b0, m_act[i]});
            check("R5", {16'b0, dev_base[16*i +: 16]}, {16'b0, m_base[i]});
            check("R6", {24'b0, dev_irq[8*i +: 8]}, {24'b0, m_irq[i]});
            check("R7", {16'b0, dev_dma1[8*i +: 8], dev_dma0[8*i +: 8]},
                  {16'b0, m_dma1[i], m_dma0[i]});
            check("R8", {24'b0, dev_rchk[8*i +: 8]}, {24'b0, exp_rchk(i)});
        end
    endtask

    function automatic logic [7:0] pick_idx(input int r);
        case (r % 16)
            0: return 8'h07;  1: return 8'h20;  2: return 8'h30;  3: return 8'h31;
            4: return 8'h60;  5: return 8'h61;  6: return 8'h70;  7: return 8'h71;
            8: return 8'h74;  9: return 8'h75;  10: return 8'h00; 11: return 8'h21;
            12: return 8'h40; 13: return 8'h62; 14: return 8'h7F; default: return 8'hF0;
        endcase
    endfunction

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    endtask

    // Watchdog
    initial begin
        #(20 * 150000);
        if (!done) begin
            nfail++;
            $display("FAIL watchdog expired actual=running expected=done");
            finish_run();
        end
    end

    initial begin
        logic [7:0] ix, d;
        void'($urandom(32'd20240607));
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11: reset state
        check("R11", {31'b0, (dev_active == '0)}, 32'd1);
        check("R11", {31'b0, (dev_base == '0 && dev_irq == '0 && dev_dma0 == '0 && dev_dma1 == '0 && dev_rchk == '0)}, 32'd1);
        check_all();

        // R3: identifier read and write-ignore
        acc(1'b0, 8'h20); check_all();
        acc(1'b1, 8'h00); check_all();
        acc(1'b1, 8'hFF); check_all();

        // R8: range-check cycle on device 3
        acc(1'b0, 8'h07); acc(1'b1, 8'h03);
        acc(1'b0, 8'h31); acc(1'b1, 8'h03); check_all();
        check("R8", {24'b0, dev_rchk[24 +: 8]}, 32'h55);
        acc(1'b1, 8'hFE); check_all();
        check("R8", {24'b0, dev_rchk[24 +: 8]}, 32'hAA);
        acc(1'b0, 8'h30); acc(1'b1, 8'h01); check_all();
        check("R8", {24'b0, dev_rchk[24 +: 8]}, 32'h00);
        acc(1'b1, 8'h00);
        acc(1'b0, 8'h31); acc(1'b1, 8'h01); check_all();
        check("R8", {24'b0, dev_rchk[24 +: 8]}, 32'h00);

        // R10: selector 9 gates all bank writes
        acc(1'b0, 8'h07); acc(1'b1, 8'h09);
        acc(1'b0, 8'h60); acc(1'b1, 8'hA5); check_all();
        acc(1'b0, 8'h30); acc(1'b1, 8'h01); check_all();

        // R9: unimplemented index write
        acc(1'b0, 8'h07); acc(1'b1, 8'h00);
        acc(1'b0, 8'h62); acc(1'b1, 8'h77); check_all();

        // Random mix
        for (int n = 0; n < 1500; n++) begin
            ix = pick_idx(int'($urandom));
            acc(1'b0, ix);
            if (ix == 8'h07) d = 8'($urandom % 11);
            else d = 8'($urandom);
            acc(1'b1, d);
            check_all();
        end

        done = 1;
        finish_run();
    end
endmodule